// File: doc/BRIEF.md
# Compatibility Printer Port Register Model

This block gives a host a byte-wide view of a classic printer port with three registers: the outgoing/incoming data byte, a status byte and a control byte. A simple single-cycle read/write bus with a small offset selects the register. Reads are combinational from the current register contents. Any side effect of an access lands on the clock edge that ends the access.

There is no real printer behind the port. The block imitates one internally. A rising strobe written through the control register sends the held data byte out on a byte stream with a one-cycle valid pulse. Repeated status reads walk the busy and acknowledge bits through a printer handshake. A level interrupt tells the host that a strobe was dropped while interrupts were enabled. An input byte can be captured from an external port with a load pulse, and read back when the direction bit selects input.

Top module: `pport_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, status reads 0xD9, control reads 0xCC and irqOut is 0.
- R2: Only the low 3 address bits select a register: offset 0 is data, 1 is status, 2 is control. Offsets 3 to 7 read 0xFF, and writes to them change nothing. Higher address bits alias onto the same registers.
- R3: Every stored control value has bits 7 and 6 set, whatever was written.
- R4: A control write with bit 2 (initialise, active low) equal to 0 loads status with 0xD8.
- R5: A control write with bits 2, 3 and 0 all 1 clears status bit 7. If the previously stored control bit 0 was 0, the same write also emits the current data byte: outValid is high for exactly the one cycle after the write edge, with outByte equal to that byte.
- R6: A control write with bits 2 and 3 equal to 1 and bit 0 equal to 0 sets interrupt pending only if bit 4 of the previously stored control value was 1.
- R7: With control bit 5 equal to 1, a data read returns the byte captured from inByte on the last inLoad cycle. With bit 5 equal to 0, it returns the last written data byte.
- R8: A status read returns the status value as it stood before the read, and clears interrupt pending. If status bit 7 and control bit 0 are both 0, the read then updates status: it clears bit 6 if bit 6 was set, and otherwise sets both bit 6 and bit 7.
- R9: irqOut always equals the interrupt-pending flag. It changes only after a control write or a status read, and a data write leaves it unchanged.
- R10: A control write with bit 2 equal to 1 and bit 3 (select) equal to 0 changes neither status nor the interrupt flag, and emits no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register offset (low 3 bits decoded) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| inByte | input | 8 | External input byte |
| inLoad | input | 1 | Capture inByte into the input latch |
| outByte | output | 8 | Emitted data byte |
| outValid | output | 1 | One-cycle valid for outByte |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with ADDR_W = 4 instead of the default 3. That makes addresses with bit 3 set reachable, so the bench can show that they alias onto the same three registers, while offsets 3 to 7 still read as 0xFF. The rest of the bench walks the strobe-edge emission, the busy/acknowledge stepping driven by status reads, and the interrupt gating by the previous enable bit. Emitted bytes are predicted into a queue and compared as outValid pulses appear.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int BYTE_W = 8;
  localparam int DEC_W  = 3;

  // decoded register offsets
  localparam logic [DEC_W-1:0] OFS_DATA = 3'd0;
  localparam logic [DEC_W-1:0] OFS_STAT = 3'd1;
  localparam logic [DEC_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STROBE = 0;
  localparam int C_INIT   = 2;
  localparam int C_SELECT = 3;
  localparam int C_INTEN  = 4;
  localparam int C_DIR    = 5;

  // status bit positions
  localparam int S_BUSY = 7;
  localparam int S_ACK  = 6;

  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] IDLE_READ  = 8'hFF;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic loadInit;
    logic clrBusy;
    logic emitByte;
    logic setIrq;
    logic clrIrq;
    logic clrAck;
    logic setAckBusy;
  } strobes_t;
endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrStrobe,
  input  logic              wrInit,
  input  logic              wrSelect,
  input  logic              prevStrobe,
  input  logic              prevIntEn,
  input  logic              stBusy,
  input  logic              stAck,
  output strobes_t          strb
);
  logic [DEC_W-1:0] ofs;
  logic isWr, isRd, ctrlWr, statRd, armed, stepOk;

  assign ofs    = busAddr[DEC_W-1:0];
  assign isWr   = busSel && busWr;
  assign isRd   = busSel && !busWr;
  assign ctrlWr = isWr && (ofs == OFS_CTRL);
  assign statRd = isRd && (ofs == OFS_STAT);
  assign armed  = ctrlWr && wrInit && wrSelect;
  assign stepOk = statRd && !stBusy && !prevStrobe;

  always_comb begin
    strb            = '0;
    strb.wrData     = isWr && (ofs == OFS_DATA);
    strb.wrCtrl     = ctrlWr;
    strb.loadInit   = ctrlWr && !wrInit;
    strb.clrBusy    = armed && wrStrobe;
    strb.emitByte   = armed && wrStrobe && !prevStrobe;
    strb.setIrq     = armed && !wrStrobe && prevIntEn;
    strb.clrIrq     = statRd;
    strb.clrAck     = stepOk && stAck;
    strb.setAckBusy = stepOk && !stAck;
  end
endmodule

// File: rtl/pport_datapath.sv
module pport_datapath
  import pport_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inLoad,
  output logic [BYTE_W-1:0] busRdata,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic [BYTE_W-1:0] statQ,
  output logic [BYTE_W-1:0] outByte,
  output logic              outValid,
  output logic              irqOut
);
  logic [BYTE_W-1:0] dataW, dataR;
  logic irqPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataW    <= DATA_RST;
      dataR    <= DATA_RST;
      statQ    <= STAT_RST;
      ctrlQ    <= CTRL_RST;
      irqPend  <= 1'b0;
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      if (strb.wrData) dataW <= busWdata;
      if (inLoad)      dataR <= inByte;
      if (strb.wrCtrl) ctrlQ <= busWdata | CTRL_FORCE;

      if (strb.loadInit)        statQ <= STAT_INIT;
      else if (strb.clrBusy)    statQ[S_BUSY] <= 1'b0;
      else if (strb.clrAck)     statQ[S_ACK] <= 1'b0;
      else if (strb.setAckBusy) begin
        statQ[S_ACK]  <= 1'b1;
        statQ[S_BUSY] <= 1'b1;
      end

      if (strb.setIrq)      irqPend <= 1'b1;
      else if (strb.clrIrq) irqPend <= 1'b0;

      outValid <= strb.emitByte;
      if (strb.emitByte) outByte <= dataW;
    end
  end

  assign irqOut = irqPend;

  always_comb begin
    unique case (busAddr[DEC_W-1:0])
      OFS_DATA: busRdata = ctrlQ[C_DIR] ? dataR : dataW;
      OFS_STAT: busRdata = statQ;
      OFS_CTRL: busRdata = ctrlQ;
      default:  busRdata = IDLE_READ;
    endcase
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [7:0]        inByte,
  input  logic              inLoad,
  output logic [7:0]        outByte,
  output logic              outValid,
  output logic              irqOut
);
  strobes_t strb;
  logic [BYTE_W-1:0] ctrlQ, statQ;

  pport_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .wrStrobe   (busWdata[C_STROBE]),
    .wrInit     (busWdata[C_INIT]),
    .wrSelect   (busWdata[C_SELECT]),
    .prevStrobe (ctrlQ[C_STROBE]),
    .prevIntEn  (ctrlQ[C_INTEN]),
    .stBusy     (statQ[S_BUSY]),
    .stAck      (statQ[S_ACK]),
    .strb       (strb)
  );

  pport_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .inByte   (inByte),
    .inLoad   (inLoad),
    .busRdata (busRdata),
    .ctrlQ    (ctrlQ),
    .statQ    (statQ),
    .outByte  (outByte),
    .outValid (outValid),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/pport_regs_checker.sv
module pport_regs_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              outValid,
  input logic              irqOut
);
  logic rdCtrl, rdStat, rdIdle, wrCtrl;
  assign rdCtrl = busSel && !busWr && (busAddr[2:0] == 3'd2);
  assign rdStat = busSel && !busWr && (busAddr[2:0] == 3'd1);
  assign rdIdle = busSel && !busWr && (busAddr[2:0] > 3'd2);
  assign wrCtrl = busSel && busWr && (busAddr[2:0] == 3'd2);

  AST_CTRL_TOP_SET: assert property (@(posedge clk) disable iff (!rstN)
    rdCtrl |-> (busRdata[7:6] == 2'b11)); // R3
  AST_IDLE_OFS_FF: assert property (@(posedge clk) disable iff (!rstN)
    rdIdle |-> (busRdata == 8'hFF)); // R2
  AST_EMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R5
  AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(wrCtrl && busWdata[0] && busWdata[2] && busWdata[3])); // R5
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    rdStat |=> !irqOut); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(wrCtrl && !busWdata[0])); // R6
endmodule

bind pport_regs pport_regs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .outValid(outValid), .irqOut(irqOut)
);

// File: tb/pport_regs_bench.sv
`timescale 1ns/1ps
module pport_regs_bench;
  localparam int AW = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, inLoad = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0] busWdata = '0, inByte = '0;
  logic [7:0] busRdata, outByte;
  logic outValid, irqOut;
  int checks = 0, errors = 0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  pport_regs #(.ADDR_W(AW)) u_pport_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .inByte(inByte), .inLoad(inLoad),
    .outByte(outByte), .outValid(outValid), .irqOut(irqOut));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 check(req, busRdata, exp);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // emitting write: driver pushes the predicted byte
  task automatic wrEmit(input logic [7:0] d, input logic [7:0] byteExp);
    expQ.push_back(byteExp);
    wr(4'd2, d);
  endtask

  // monitor: pop and compare every emitted byte
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 actual=%h expected=no byte", outByte);
      end else begin
        check("R5 emitted byte", outByte, expQ.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 4'd2, 8'hCC);
    rd("R1 status", 4'd1, 8'hD9);
    rd("R1 data", 4'd0, 8'hFF);
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    // R2 unused offsets and aliasing
    rd("R2 ofs3", 4'd3, 8'hFF);
    rd("R2 ofs7", 4'd7, 8'hFF);
    rd("R2 alias ctrl", 4'hA, 8'hCC);
    // data write/read
    wr(4'd0, 8'h5A);
    rd("R7 data write readback", 4'd0, 8'h5A);
    // R3, R4
    wr(4'd2, 8'h00);
    rd("R3 forced top bits", 4'd2, 8'hC0);
    rd("R4 init loads status", 4'd1, 8'hD8);
    // strobe low, interrupts disabled previously
    wr(4'd2, 8'h0C);
    check("R6 no irq without prior enable", {7'd0, irqOut}, 8'h00);
    // R5 rising strobe emits
    wrEmit(8'h0D, 8'h5A);
    rd("R5 busy cleared", 4'd1, 8'h58);
    rd("R8 no step while strobe high", 4'd1, 8'h58);
    wr(4'd2, 8'h0D); // strobe already high: no emission
    wr(4'd2, 8'h0C);
    // R8 handshake stepping
    rd("R8 step1", 4'd1, 8'h58);
    rd("R8 step2", 4'd1, 8'h18);
    rd("R8 step3", 4'd1, 8'hD8);
    rd("R8 steady", 4'd1, 8'hD8);
    // R6 / R9 interrupt
    wr(4'd2, 8'h1C);
    check("R6 enable not yet effective", {7'd0, irqOut}, 8'h00);
    wr(4'd2, 8'h1C);
    check("R6 irq set", {7'd0, irqOut}, 8'h01);
    wr(4'd0, 8'h33);
    check("R9 data write keeps irq", {7'd0, irqOut}, 8'h01);
    rd("R8 status value on irq read", 4'd1, 8'hD8);
    check("R8 irq cleared by status read", {7'd0, irqOut}, 8'h00);
    // R10 select low
    wr(4'd2, 8'h15);
    rd("R10 status unchanged", 4'd1, 8'hD8);
    wr(4'd2, 8'h14);
    check("R10 no irq", {7'd0, irqOut}, 8'h00);
    // R7 direction
    inByte = 8'hA7; inLoad = 1'b1;
    @(negedge clk);
    inLoad = 1'b0; inByte = 8'h00;
    wr(4'd2, 8'h24);
    rd("R7 input latch", 4'd0, 8'hA7);
    wr(4'd0, 8'h11);
    rd("R7 input latch kept", 4'd0, 8'hA7);
    wr(4'd2, 8'h04);
    rd("R7 output latch", 4'd0, 8'h11);
    // second emission
    wr(4'd2, 8'h0C);
    wr(4'd0, 8'h96);
    wrEmit(8'h0D, 8'h96);
    rd("R5 busy cleared again", 4'd1, 8'h58);
    // R2 write to unused offset ignored
    wr(4'd5, 8'h00);
    rd("R2 ctrl unchanged", 4'd2, 8'hCD);
    rd("R2 data unchanged", 4'd0, 8'h96);
    repeat (4) @(negedge clk);
    check("R5 all bytes seen", 8'(expQ.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule